// File: doc/BRIEF.md
# Configurable Serial Frame Transmitter

This block serialises one parallel character into an asynchronous frame on a single output line. The line idles high (mark). A frame is one low start bit, then a character field of fixed length, then one high stop bit, all in NRZ form. Each bit lasts exactly one period of an external per-bit baud enable.

The character field is 8 or 9 slots long. With parity off, every slot carries a data bit. With parity on, the last slot of the field carries the parity bit. The frame length therefore depends only on the field length. Data bits go out in either ascending order (bit 0 first) or descending order (highest sent bit first). The parity bit always follows the data bits. Parity can be even or odd.

A character enters on a valid/ready handshake. Length, parity enable, parity type and bit order are sampled at that handshake. They hold for the whole frame, whatever the inputs do afterwards.

Top module: `uart_frame_tx`

## Requirements
- R1: After reset and whenever no frame is in progress, `txd_o` is 1, `busy_o` is 0 and `ready_o` is 1.
- R2: A character is taken only in a cycle with `valid_i` and `ready_o` both high. From the next cycle `busy_o` is 1 and `ready_o` is 0. While busy, `valid_i` and `data_i` have no effect on the frame being sent.
- R3: The first `baud_en_i` pulse after acceptance starts the start bit (`txd_o`=0). Every bit of the frame holds its value until the next `baud_en_i` pulse, so each bit lasts exactly one baud period.
- R4: After the start bit come 9 field slots when `nine_bit_i`=1 and 8 when it is 0. Then comes a stop bit of 1. `busy_o` falls at the `baud_en_i` pulse that ends the stop bit.
- R5: With `msb_first_i`=0, the data bits are sent from bit 0 upward.
- R6: With `msb_first_i`=1, the data bits are sent from the highest sent bit down to bit 0.
- R7: With `par_en_i`=1, the last field slot carries the parity bit. Only bits 0..6 (8-slot field) or bits 0..7 (9-slot field) are sent as data. The frame length is unchanged.
- R8: With `par_odd_i`=0, the sent data bits plus the parity bit hold an even number of ones. With `par_odd_i`=1 they hold an odd number.
- R9: Changes to `nine_bit_i`, `par_en_i`, `par_odd_i`, `msb_first_i` and `data_i` after acceptance do not alter the frame in progress.
- R10: Bits of `data_i` above the highest sent data bit have no effect on the line or on the parity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| data_i | input | 9 | Character to send |
| valid_i | input | 1 | Character offered |
| ready_o | output | 1 | Block can take a character |
| baud_en_i | input | 1 | One-cycle pulse per bit period |
| nine_bit_i | input | 1 | 1: 9-slot field, 0: 8-slot field |
| par_en_i | input | 1 | Last field slot carries parity |
| par_odd_i | input | 1 | 1: odd parity, 0: even parity |
| msb_first_i | input | 1 | 1: descending data order |
| busy_o | output | 1 | Frame accepted and not yet finished |
| txd_o | output | 1 | Serial line, idles high |

## Verification
The assertions assume that `baud_en_i` is a single-cycle pulse. They also assume that the handshake inputs are stable around the clock edge. The bench drives every input on the falling edge and raises `baud_en_i` for exactly one cycle, with zero to two idle cycles between pulses. The configuration inputs are deliberately re-randomised right after each handshake, and `valid_i` is raised during frames, so that the sampling and ignore rules are exercised within those assumptions.

// File: rtl/uftx_pkg.sv
package uftx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ARM  = 2'd1,
    ST_SEND = 2'd2
  } tx_state_e;
endpackage

// File: rtl/uftx_framer.sv
module uftx_framer #(
  parameter int CHAR_W_MAX = 9,
  localparam int FRAME_W   = CHAR_W_MAX + 2,
  localparam int CNT_W     = $clog2(FRAME_W + 1),
  localparam int IDX_W     = $clog2(CHAR_W_MAX)
) (
  input  logic [CHAR_W_MAX-1:0] data_i,
  input  logic                  nine_bit_i,
  input  logic                  par_en_i,
  input  logic                  par_odd_i,
  input  logic                  msb_first_i,
  output logic [FRAME_W-1:0]    frame_o,
  output logic [CNT_W-1:0]      slots_o
);
  localparam logic [CNT_W-1:0] CW_LONG  = CNT_W'(CHAR_W_MAX);
  localparam logic [CNT_W-1:0] CW_SHORT = CNT_W'(CHAR_W_MAX - 1);

  logic [CNT_W-1:0]      char_w;
  logic [CNT_W-1:0]      n_data;
  logic [CHAR_W_MAX-1:0] sent;
  logic                  par_bit;

  assign char_w  = nine_bit_i ? CW_LONG : CW_SHORT;
  assign n_data  = char_w - CNT_W'(par_en_i);
  assign slots_o = char_w + CNT_W'(2);

  for (genvar s = 0; s < CHAR_W_MAX; s++) begin : g_slot
    logic [IDX_W-1:0] rev_idx;
    logic             dbit;
    // bits beyond the sent count are masked out of parity
    assign sent[s]  = data_i[s] & (CNT_W'(s) < n_data);
    assign rev_idx  = IDX_W'(n_data - CNT_W'(s) - CNT_W'(1));
    assign dbit     = msb_first_i ? data_i[rev_idx] : data_i[s];
    always_comb begin
      if (CNT_W'(s) < n_data)       frame_o[s+1] = dbit;
      else if (CNT_W'(s) == n_data) frame_o[s+1] = par_en_i ? par_bit : 1'b1;
      else                          frame_o[s+1] = 1'b1;
    end
  end

  assign par_bit            = (^sent) ^ par_odd_i;
  assign frame_o[0]         = 1'b0;
  assign frame_o[FRAME_W-1] = 1'b1;
endmodule

// File: rtl/uftx_seq.sv
module uftx_seq
  import uftx_pkg::*;
#(
  parameter int FRAME_W = 11,
  localparam int CNT_W  = $clog2(FRAME_W + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               accept_i,
  input  logic               baud_en_i,
  input  logic [FRAME_W-1:0] frame_i,
  input  logic [CNT_W-1:0]   slots_i,
  output logic               busy_o,
  output logic               txd_o
);
  tx_state_e          state_q;
  logic [FRAME_W-1:0] sreg_q;
  logic [CNT_W-1:0]   left_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      sreg_q  <= '1;
      left_q  <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (accept_i) begin
          sreg_q  <= frame_i;
          left_q  <= slots_i;
          state_q <= ST_ARM;
        end
        // wait for a bit boundary so the start bit gets a full period
        ST_ARM: if (baud_en_i) state_q <= ST_SEND;
        ST_SEND: if (baud_en_i) begin
          if (left_q == CNT_W'(1)) begin
            state_q <= ST_IDLE;
          end else begin
            sreg_q <= {1'b1, sreg_q[FRAME_W-1:1]};
            left_q <= left_q - CNT_W'(1);
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o = (state_q != ST_IDLE);
  assign txd_o  = (state_q == ST_SEND) ? sreg_q[0] : 1'b1;

  a_r1_idle_mark: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> txd_o);
  a_r2_accept_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_i |=> busy_o);
  a_r3_start_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ARM && baud_en_i) |=> !txd_o);
  a_r3_bit_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SEND && !baud_en_i) |=> $stable(txd_o));
  a_r4_stop_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SEND && left_q == CNT_W'(1)) |-> txd_o);
endmodule

// File: rtl/uart_frame_tx.sv
module uart_frame_tx #(
  parameter int CHAR_W_MAX = 9,
  localparam int FRAME_W   = CHAR_W_MAX + 2,
  localparam int CNT_W     = $clog2(FRAME_W + 1)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [CHAR_W_MAX-1:0] data_i,
  input  logic                  valid_i,
  output logic                  ready_o,
  input  logic                  baud_en_i,
  input  logic                  nine_bit_i,
  input  logic                  par_en_i,
  input  logic                  par_odd_i,
  input  logic                  msb_first_i,
  output logic                  busy_o,
  output logic                  txd_o
);
  logic [FRAME_W-1:0] frame_w;
  logic [CNT_W-1:0]   slots_w;
  logic               accept_w;

  assign ready_o  = !busy_o;
  assign accept_w = valid_i && ready_o;

  uftx_framer #(.CHAR_W_MAX(CHAR_W_MAX)) u_framer (
    .data_i      (data_i),
    .nine_bit_i  (nine_bit_i),
    .par_en_i    (par_en_i),
    .par_odd_i   (par_odd_i),
    .msb_first_i (msb_first_i),
    .frame_o     (frame_w),
    .slots_o     (slots_w)
  );

  uftx_seq #(.FRAME_W(FRAME_W)) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .accept_i  (accept_w),
    .baud_en_i (baud_en_i),
    .frame_i   (frame_w),
    .slots_i   (slots_w),
    .busy_o    (busy_o),
    .txd_o     (txd_o)
  );

  // field slots (data plus parity) must hold the selected parity
  a_r8_parity_sum: assert property (@(posedge clk_i) disable iff (!rst_ni)
    par_en_i |-> ((nine_bit_i ? ^frame_w[CHAR_W_MAX:1] : ^frame_w[CHAR_W_MAX-1:1])
                  == par_odd_i));
endmodule

// File: tb/sim_uart_frame_tx.sv
`timescale 1ns/1ps
module sim_uart_frame_tx;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [8:0] data = '0;
  logic       valid = 1'b0, baud = 1'b0;
  logic       nine = 1'b0, par = 1'b0, odd = 1'b0, msb = 1'b0;
  logic       ready, busy, txd;
  int         n_vec = 0, n_bad = 0;

  always #5 clk = ~clk;

  uart_frame_tx u0 (
    .clk_i(clk), .rst_ni(rst_ni), .data_i(data), .valid_i(valid), .ready_o(ready),
    .baud_en_i(baud), .nine_bit_i(nine), .par_en_i(par), .par_odd_i(odd),
    .msb_first_i(msb), .busy_o(busy), .txd_o(txd)
  );

  task automatic chk(input logic got, input logic exp, input string req);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got %0b exp %0b at %0t", req, got, exp, $time);
    end
  endtask

  function automatic int build_exp(input logic [8:0] d, input bit nn, input bit pe,
                                   input bit po, input bit mf, output bit f[11]);
    int cw = nn ? 9 : 8;
    int nd = cw - (pe ? 1 : 0);
    int ones = 0;
    f[0] = 1'b0;
    for (int s = 0; s < nd; s++) begin
      f[s+1] = mf ? d[nd-1-s] : d[s];
      ones += int'(d[s]);
    end
    if (pe) f[nd+1] = bit'(ones & 1) ^ po;
    f[cw+1] = 1'b1;
    return cw + 2;
  endfunction

  task automatic pulse();
    baud = 1'b1;
    @(negedge clk);
    baud = 1'b0;
  endtask

  task automatic send(input logic [8:0] d, input bit nn, input bit pe, input bit po,
                      input bit mf, input bit poke, input string dtag);
    bit    f[11];
    int    n;
    string tag;
    n = build_exp(d, nn, pe, po, mf, f);
    @(negedge clk);
    data = d; nine = nn; par = pe; odd = po; msb = mf; valid = 1'b1;
    @(negedge clk);
    valid = 1'b0;
    chk(busy, 1'b1, "R2 busy after accept");
    chk(ready, 1'b0, "R2 ready low while busy");
    chk(txd, 1'b1, "R3 line high before first baud pulse");
    // R9: scramble everything after acceptance
    data = 9'($urandom); nine = $urandom; par = $urandom; odd = $urandom; msb = $urandom;
    repeat ($urandom_range(0, 2)) @(negedge clk);
    pulse();
    for (int j = 0; j < n; j++) begin
      int g = $urandom_range(0, 2);
      if (j == 0) tag = "R3 start bit";
      else if (j == n - 1) tag = "R4 stop bit";
      else if (pe && j == n - 2) tag = po ? "R8 odd parity slot" : "R7 parity slot";
      else if (dtag != "") tag = dtag;
      else tag = mf ? "R6 descending data" : "R5 ascending data";
      if (poke && j == 2) begin
        valid = 1'b1;
        data  = 9'($urandom);
      end
      for (int k = 0; k <= g; k++) begin
        chk(txd, f[j], tag);
        if (k < g) @(negedge clk);
      end
      if (poke && j == 2) chk(ready, 1'b0, "R2 valid ignored while busy");
      pulse();
      if (poke && j == 2) valid = 1'b0;
    end
    chk(busy, 1'b0, "R4 busy falls after stop");
    chk(ready, 1'b1, "R1 ready when idle");
    chk(txd, 1'b1, "R1 line idles high");
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk(txd, 1'b1, "R1 reset line high");
    chk(busy, 1'b0, "R1 reset not busy");
    chk(ready, 1'b1, "R1 reset ready");
    rst_ni = 1'b1;
    @(negedge clk);
    baud = 1'b1; // stray pulse while idle
    @(negedge clk);
    baud = 1'b0;
    chk(txd, 1'b1, "R1 idle ignores baud pulse");
    send(9'h0A5, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R5 8-slot ascending");
    send(9'h0A5, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, "R6 8-slot descending");
    send(9'h1C3, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R4 9-slot ascending");
    send(9'h1C3, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, "R6 9-slot descending");
    send(9'h035, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R7 8-slot even parity");
    send(9'h035, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, "R8 8-slot odd parity");
    send(9'h0F1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, "R7 9-slot odd parity");
    send(9'h180, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R10 upper bits masked");
    send(9'h100, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, "R10 bit 8 unused");
    send(9'h1FF, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, "R7 all ones");
    for (int i = 0; i < 300; i++)
      send(9'($urandom), $urandom, $urandom, $urandom, $urandom, $urandom, "");
    finish_run();
  end
endmodule